// File: doc/BRIEF.md
# Shared-Period Multi-Channel PWM Timer

This block produces up to four pulse-width-modulated outputs that all run on one common period while each output keeps its own duty. A clock divider slows the timer clock by a programmable factor. A counter steps upward from zero once per divided tick and returns to zero after it reaches a programmable limit. Each channel compares the counter against its own threshold to form its output level.

Software programs the block through a single-cycle write port. Each channel's threshold sits behind a staging register. When staging is enabled for that channel, a new threshold waits for the next counter wrap, so no period is ever built from two different thresholds. When staging is disabled, the new threshold applies on the next clock. The period limit can be staged in the same way. The divider value is always staged. A one-clock pulse marks every counter wrap.

Top module: `pwm_timer`

## Requirements
- R1: While `rst` is high, `pwm_o` and `update_o` are 0. Reset clears the divider, the control word and every threshold to 0 and sets the period limit to `ARR_RESET`.
- R2: The counter steps up by one on every divided tick. On the tick where it is at or above the active limit L, it returns to 0 instead. With a divider value D, one period lasts (D+1)*(L+1) clocks.
- R3: `update_o` is high for exactly one clock per counter wrap: the first clock in which the counter holds 0.
- R4: With the polarity bit clear, the output of channel i is 1 while counter >= threshold C and 0 below it. The output is registered one clock after the counter value, and it is high for (D+1)*(L+1-C) clocks of each period.
- R5: With the polarity bit set, channel i is 1 while counter < C. It is then high for (D+1)*C clocks of each period.
- R6: C = 0 gives a constant level for the whole period: high with the polarity bit clear, low with it set. C > L gives the opposite constant level.
- R7: With staging enabled for channel i, a threshold write takes effect only at the next counter wrap. With staging disabled, it takes effect from the next counter value.
- R8: With limit staging enabled, a write to the limit applies from the next period. With it disabled, the limit applies at once.
- R9: A divider write always takes effect at the next counter wrap.
- R10: All channels share one counter and one limit, so they have the same period and independent duties.
- R11: Write map (`wr_addr`): 0 = divider, 1 = period limit, 2 = control, 4+i = threshold of channel i. Control bit i enables staging for channel i, bit NCH+i is the polarity of channel i, and bit 2*NCH enables limit staging. Writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one write per clock |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| pwm_o | output | NCH | Registered PWM outputs, one per channel |
| update_o | output | 1 | One-clock pulse at each counter wrap |

## Verification
The tests drive each channel's threshold to 0 and above the limit. A design with an off-by-one compare would leave a one-clock glitch in what should be a flat level. Threshold and limit writes land in the middle of a period, with staging enabled and then disabled. A design that staged too early would change the current period, and one that staged too late would lose the new value. The bench also checks that a divider change waits for the next wrap, looks at the exact clock where each output rises within a period, and confirms that writes to unmapped addresses leave both duty and period unchanged.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  // Write map
  localparam int ADDR_DIV   = 0;
  localparam int ADDR_LIMIT = 1;
  localparam int ADDR_CTRL  = 2;
  localparam int ADDR_THR0  = 4;

  // Control word layout
  function automatic int stage_bit(input int ch);
    return ch;
  endfunction

  function automatic int pol_bit(input int nch, input int ch);
    return nch + ch;
  endfunction

  function automatic int limit_stage_bit(input int nch);
    return 2 * nch;
  endfunction

  function automatic int ctrl_width(input int nch);
    return 2 * nch + 1;
  endfunction
endpackage

// File: rtl/pwm_regfile.sv
module pwm_regfile
  import pwm_timer_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 4,
  localparam int CTRL_W = ctrl_width(NCH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [CTRL_W-1:0] wr_ctrl,
  output logic              div_we,
  output logic              limit_we,
  output logic [NCH-1:0]    thr_we,
  output logic [NCH-1:0]    thr_stage,
  output logic [NCH-1:0]    thr_pol,
  output logic              limit_stage
);
  logic ctrl_we;

  always_comb begin
    div_we   = wr_en && (wr_addr == AW'(ADDR_DIV));
    limit_we = wr_en && (wr_addr == AW'(ADDR_LIMIT));
    ctrl_we  = wr_en && (wr_addr == AW'(ADDR_CTRL));
  end

  for (genvar i = 0; i < NCH; i++) begin : g_dec
    assign thr_we[i] = wr_en && (wr_addr == AW'(ADDR_THR0 + i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_stage   <= '0;
      thr_pol     <= '0;
      limit_stage <= 1'b0;
    end else if (ctrl_we) begin
      for (int i = 0; i < NCH; i++) begin
        thr_stage[i] <= wr_ctrl[stage_bit(i)];
        thr_pol[i]   <= wr_ctrl[pol_bit(NCH, i)];
      end
      limit_stage <= wr_ctrl[limit_stage_bit(NCH)];
    end
  end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CW = 16,
  parameter int PW = 16,
  parameter logic [CW-1:0] ARR_RESET = '1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          div_we,
  input  logic [PW-1:0] div_wdata,
  input  logic          limit_we,
  input  logic [CW-1:0] limit_wdata,
  input  logic          limit_stage,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] limit_act,
  output logic          wrap,
  output logic          update_o
);
  logic [PW-1:0] div_pend, div_act, div_cnt;
  logic [CW-1:0] limit_pend;
  logic          tick;

  always_comb begin
    tick = (div_cnt >= div_act);
    wrap = tick && (cnt >= limit_act);
  end

  // Divider: a new value is always held until the next wrap
  always_ff @(posedge clk) begin
    if (rst) begin
      div_pend <= '0;
      div_act  <= '0;
      div_cnt  <= '0;
    end else begin
      if (div_we) div_pend <= div_wdata;
      if (wrap)   div_act  <= div_pend;
      div_cnt <= tick ? '0 : div_cnt + PW'(1);
    end
  end

  // Period limit: staged or immediate
  always_ff @(posedge clk) begin
    if (rst) begin
      limit_pend <= ARR_RESET;
      limit_act  <= ARR_RESET;
    end else begin
      if (limit_we) limit_pend <= limit_wdata;
      if (limit_we && !limit_stage) limit_act <= limit_wdata;
      else if (wrap)                limit_act <= limit_pend;
    end
  end

  // Counter and update pulse
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      update_o <= 1'b0;
    end else begin
      if (tick) cnt <= wrap ? '0 : cnt + CW'(1);
      update_o <= wrap;
    end
  end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          thr_we,
  input  logic [CW-1:0] thr_wdata,
  input  logic          stage_en,
  input  logic          pol,
  input  logic          wrap,
  input  logic [CW-1:0] cnt,
  output logic [CW-1:0] thr_act,
  output logic          pwm_o
);
  logic [CW-1:0] thr_pend;
  logic          at_or_above;

  assign at_or_above = (cnt >= thr_act);

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_pend <= '0;
      thr_act  <= '0;
      pwm_o    <= 1'b0;
    end else begin
      if (thr_we) thr_pend <= thr_wdata;
      if (thr_we && !stage_en)  thr_act <= thr_wdata;
      else if (wrap && stage_en) thr_act <= thr_pend;
      pwm_o <= pol ^ at_or_above;
    end
  end
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
  import pwm_timer_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = 16,
  parameter int PW  = 16,
  parameter int AW  = 4,
  parameter int DW  = 16,
  parameter logic [CW-1:0] ARR_RESET = '1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [DW-1:0]  wr_data,
  output logic [NCH-1:0] pwm_o,
  output logic           update_o
);
  localparam int CTRL_W = ctrl_width(NCH);

  logic           div_we, limit_we, limit_stage, wrap;
  logic [NCH-1:0] thr_we, thr_stage, thr_pol;
  logic [CW-1:0]  cnt, limit_act;
  logic [NCH*CW-1:0] thr_flat;

  pwm_regfile #(.NCH(NCH), .AW(AW)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_ctrl     (wr_data[CTRL_W-1:0]),
    .div_we      (div_we),
    .limit_we    (limit_we),
    .thr_we      (thr_we),
    .thr_stage   (thr_stage),
    .thr_pol     (thr_pol),
    .limit_stage (limit_stage)
  );

  pwm_timebase #(.CW(CW), .PW(PW), .ARR_RESET(ARR_RESET)) u_tb (
    .clk         (clk),
    .rst         (rst),
    .div_we      (div_we),
    .div_wdata   (wr_data[PW-1:0]),
    .limit_we    (limit_we),
    .limit_wdata (wr_data[CW-1:0]),
    .limit_stage (limit_stage),
    .cnt         (cnt),
    .limit_act   (limit_act),
    .wrap        (wrap),
    .update_o    (update_o)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    pwm_channel #(.CW(CW)) u_ch (
      .clk       (clk),
      .rst       (rst),
      .thr_we    (thr_we[i]),
      .thr_wdata (wr_data[CW-1:0]),
      .stage_en  (thr_stage[i]),
      .pol       (thr_pol[i]),
      .wrap      (wrap),
      .cnt       (cnt),
      .thr_act   (thr_flat[i*CW +: CW]),
      .pwm_o     (pwm_o[i])
    );
  end
endmodule

// File: rtl/pwm_timer_checker.sv
module pwm_timer_checker #(
  parameter int NCH = 4,
  parameter int CW  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              update_o,
  input logic [NCH-1:0]    pwm_o,
  input logic [CW-1:0]     cnt,
  input logic [CW-1:0]     limit_act,
  input logic              wrap,
  input logic [NCH*CW-1:0] thr_flat,
  input logic [NCH-1:0]    thr_stage,
  input logic [NCH-1:0]    thr_pol
);
  p_wrap_zero_r2: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (cnt == '0));

  p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> (cnt == $past(cnt) || cnt == $past(cnt) + CW'(1)));

  p_pulse_on_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    wrap |=> update_o);

  p_no_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> !update_o);

  p_pulse_at_zero_r3: assert property (@(posedge clk) disable iff (rst)
    update_o |-> (cnt == '0));

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    p_zero_high_r6: assert property (@(posedge clk) disable iff (rst)
      (!thr_pol[i] && thr_flat[i*CW +: CW] == '0) |=> pwm_o[i]);

    p_over_low_r6: assert property (@(posedge clk) disable iff (rst)
      (!thr_pol[i] && cnt <= limit_act && thr_flat[i*CW +: CW] > limit_act)
      |=> !pwm_o[i]);

    p_stage_hold_r7: assert property (@(posedge clk) disable iff (rst)
      (thr_stage[i] && !wrap) |=> $stable(thr_flat[i*CW +: CW]));
  end
endmodule

bind pwm_timer pwm_timer_checker #(.NCH(NCH), .CW(CW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .update_o  (update_o),
  .pwm_o     (pwm_o),
  .cnt       (cnt),
  .limit_act (limit_act),
  .wrap      (wrap),
  .thr_flat  (thr_flat),
  .thr_stage (thr_stage),
  .thr_pol   (thr_pol)
);

// File: tb/test_pwm_timer.sv
module test_pwm_timer;
  localparam int NCH = 4;
  localparam int AW  = 4;
  localparam int DW  = 16;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           wr_en = 1'b0;
  logic [AW-1:0]  wr_addr = '0;
  logic [DW-1:0]  wr_data = '0;
  logic [NCH-1:0] pwm_o;
  logic           update_o;

  int n_checks = 0;
  int n_fail   = 0;
  int hi [NCH];
  int upd_seen;

  always #5 clk = ~clk;

  pwm_timer #(.NCH(NCH), .AW(AW), .DW(DW)) i_pwm_timer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_o(pwm_o), .update_o(update_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Called at a falling edge; the write is taken at the next rising edge
  task automatic wr(input int addr, input int data);
    wr_en   = 1'b1;
    wr_addr = AW'(addr);
    wr_data = DW'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_upd();
    int guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!update_o && guard < 1000);
  endtask

  // Clocks from now to the next update pulse
  task automatic to_next(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!update_o && n < 1000);
  endtask

  // Count high clocks per channel over one period of p clocks
  task automatic measure(input int p);
    wait_upd();
    foreach (hi[c]) hi[c] = 0;
    upd_seen = 0;
    for (int j = 0; j < p; j++) begin
      @(negedge clk);
      for (int c = 0; c < NCH; c++) if (pwm_o[c]) hi[c]++;
      if (update_o) upd_seen++;
    end
  endtask

  task automatic t_reset();
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(pwm_o == '0 && update_o == 1'b0, "R1 reset outputs",
          int'({pwm_o, update_o}), 0);
    end
    rst = 1'b0;
  endtask

  task automatic t_basic();
    int n;
    wr(1, 9);  // limit 9, staging off after reset
    wr(4, 3);
    wr(5, 7);
    wr(6, 4);
    wr(7, 0);
    wait_upd();
    to_next(n);
    chk(n == 10, "R2 period (0+1)*(9+1)", n, 10);
    measure(10);
    chk(hi[0] == 7, "R4 ch0 high clocks C=3", hi[0], 7);
    chk(hi[1] == 3, "R10 ch1 independent duty C=7", hi[1], 3);
    chk(hi[3] == 10, "R6 C=0 constant high", hi[3], 10);
    chk(upd_seen == 1, "R3 one pulse per period", upd_seen, 1);
  endtask

  task automatic t_shape();
    int bad = 0;
    wait_upd();
    for (int j = 1; j <= 10; j++) begin
      @(negedge clk);
      if (pwm_o[0] != ((j - 1) >= 3)) bad++;
    end
    chk(bad == 0, "R4 rises where counter reaches threshold", bad, 0);
  endtask

  task automatic t_polarity();
    wr(2, 1 << (NCH + 2));
    measure(10);
    chk(hi[2] == 4, "R5 inverted ch2 high clocks C=4", hi[2], 4);
    wr(6, 0);
    measure(10);
    chk(hi[2] == 0, "R6 inverted C=0 constant low", hi[2], 0);
    wr(6, 12);
    wr(4, 12);
    measure(10);
    chk(hi[2] == 10, "R6 inverted C>L constant high", hi[2], 10);
    chk(hi[0] == 0, "R6 C>L constant low", hi[0], 0);
    wr(2, 0);
    wr(4, 2);
    wr(5, 2);
  endtask

  task automatic t_ignored();
    int n;
    wr(3, 16'hFFFF);
    wr(8, 0);
    wr(15, 0);
    measure(10);
    chk(hi[0] == 8, "R11 unmapped writes keep duty", hi[0], 8);
    wait_upd();
    to_next(n);
    chk(n == 10, "R11 unmapped writes keep period", n, 10);
  endtask

  task automatic t_stage_thr();
    wr(2, 1);  // staging on for ch0 only
    wait_upd();          // counter now 0
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);      // counter 3
    wr(5, 8);            // ch1 direct
    wr(4, 8);            // ch0 staged
    @(negedge clk);
    @(negedge clk);      // output reflects counter 6
    chk(pwm_o[0] == 1'b1, "R7 staged value waits for wrap", int'(pwm_o[0]), 1);
    chk(pwm_o[1] == 1'b0, "R7 unstaged value applies at once", int'(pwm_o[1]), 0);
    measure(10);
    chk(hi[0] == 2, "R7 staged value after wrap", hi[0], 2);
    chk(hi[1] == 2, "R7 unstaged ch1 duty", hi[1], 2);
  endtask

  task automatic t_stage_limit();
    int n1, n2;
    wr(2, 1 << (2 * NCH));
    wait_upd();
    wr(1, 4);
    to_next(n1);
    n1 = n1 + 1;
    to_next(n2);
    chk(n1 == 10, "R8 staged limit keeps current period", n1, 10);
    chk(n2 == 5, "R8 staged limit in next period", n2, 5);
    wr(2, 0);
    wr(1, 9);
    wait_upd();
    wr(1, 4);
    to_next(n1);
    n1 = n1 + 1;
    chk(n1 == 5, "R8 unstaged limit applies at once", n1, 5);
    wr(1, 9);
  endtask

  task automatic t_prescale();
    int n1, n2;
    wait_upd();
    wr(0, 2);
    to_next(n1);
    n1 = n1 + 1;
    to_next(n2);
    chk(n1 == 10, "R9 divider held until wrap", n1, 10);
    chk(n2 == 30, "R9 R2 period (2+1)*(9+1)", n2, 30);
    measure(30);
    chk(hi[0] == 6, "R4 high clocks with divider", hi[0], 6);
    chk(upd_seen == 1, "R3 single pulse with divider", upd_seen, 1);
    wr(0, 0);
    wait_upd();
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_shape();
    t_polarity();
    t_ignored();
    t_stage_thr();
    t_stage_limit();
    t_prescale();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule